// File: doc/BRIEF.md
# Fractional pipe clock enable DTO

This block derives per-pipe clock enables from one global reference clock. Each of four pipe instances carries a phase value over a fixed modulo of 255. An accumulator adds the phase on every reference cycle and emits a one-cycle enable whenever it wraps. Logic gated by that enable therefore runs at phase/255 of the reference rate.

Software-side logic programs an instance by presenting a reference rate and a requested pipe rate, both in kHz. A sequential divider computes the phase as the rounded-up quotient `(255*requested + reference - 1) / reference`. A result that does not fit in eight bits is clamped to 255 and reported. When either rate is zero, the instance is switched off and keeps its old phase. A status port reads back any instance's phase, modulo, enable and last requested rate.

Top module: `frac_clken_dto`

## Requirements
- R1: The modulo read back for an instance is 0 after reset and 255 once a phase has been committed to that instance.
- R2: For nonzero rates, the committed phase equals ceil(255 * requested / reference), computed as (255*requested + reference - 1) / reference.
- R3: When that quotient exceeds 255, the phase is set to 255 and `upd_clamped_o` is high in the same cycle as `upd_done_o`; otherwise it is low.
- R4: A request whose reference or requested rate is zero clears the instance enable at the accepting edge. It leaves phase and modulo unchanged and produces no `upd_done_o`.
- R5: When a computed phase is committed, the instance enable is set, and `upd_done_o` pulses for one cycle.
- R6: A request whose index is 4 or above (index field is 3 bits) changes no instance state and produces no `upd_done_o`. Reading status for such an index returns all zeros.
- R7: Every accepted request to instances 0 to 3 records the requested rate as the instance's last rate, including zero-rate requests.
- R8: While enabled, an instance's enable output pulses exactly `phase` times in any 255 consecutive reference cycles; with phase 255 it is high every cycle.
- R9: A disabled instance holds its accumulator at zero and its enable output low. After enabling from the off state, the first pulse comes ceil(255/phase) cycles after `upd_done_o`.
- R10: `req_ready_o` is low from the accepting edge of a computed request until its commit. Requests presented while it is low are ignored.
- R11: After reset, all enables are off, `req_ready_o` is high and all status fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when ready |
| req_idx_i | input | 3 | Target instance index |
| req_ref_khz_i | input | 20 | Reference rate in kHz |
| req_tgt_khz_i | input | 20 | Requested pipe rate in kHz |
| req_ready_o | output | 1 | No division in progress |
| upd_done_o | output | 1 | One-cycle pulse when a phase is committed |
| upd_clamped_o | output | 1 | Committed phase was clamped (valid with done) |
| stat_idx_i | input | 3 | Instance selected for status readback |
| stat_phase_o | output | 8 | Programmed phase |
| stat_modulo_o | output | 8 | Programmed modulo |
| stat_en_o | output | 1 | Instance enable state |
| stat_last_khz_o | output | 20 | Last requested rate |
| clk_en_o | output | 4 | Per-instance clock enable pulses |

## Verification
Some rules are checked by the embedded properties on every cycle. They cover the accumulator range, continuous enables at phase 255, and the silent, zeroed accumulator while disabled. They also cover the clamp on commit, enable-and-modulo after a commit, the zero-rate shutoff leaving the phase untouched, last-rate capture, and the fact that the divider is never restarted mid-run. Other behaviour only the bench scenarios can show. That includes the exact rounded-up phase values, the pulse count over a 255-cycle window, and the first-pulse latency after re-enabling. It also includes dropped requests while busy and out-of-range indices leaving every status field intact.

// File: rtl/frac_dto_pkg.sv
package frac_dto_pkg;
   localparam int DEF_NUM_INST = 4;
   localparam int DEF_RATE_W   = 20;
   localparam int DEF_PH_W     = 8;
   localparam int DEF_IDX_W    = 3;

   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;
endpackage

// File: rtl/frac_dto_div.sv
module frac_dto_div
   import frac_dto_pkg::*;
#(
   parameter int NUM_W = 29,
   parameter int DEN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   div_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NUM_W-1:0] sh_q;
   logic [DEN_W:0]   rem_q;
   logic [DEN_W-1:0] den_q;
   logic [DEN_W:0]   rem_sh;
   logic             fits;
   logic [DEN_W:0]   rem_nx;

   // restoring step: bring down the next dividend bit, subtract if it fits
   always_comb begin
      rem_sh = {rem_q[DEN_W-1:0], sh_q[NUM_W-1]};
      fits   = rem_sh >= {1'b0, den_q};
      rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DIV_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (st_q == DIV_IDLE) begin
            if (start_i) begin
               st_q  <= DIV_RUN;
               cnt_q <= CNT_W'(NUM_W);
               sh_q  <= num_i;
               rem_q <= '0;
               den_q <= den_i;
            end
         end else begin
            sh_q  <= {sh_q[NUM_W-2:0], fits};
            rem_q <= rem_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               st_q   <= DIV_IDLE;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign busy_o = (st_q == DIV_RUN);
   assign quo_o  = sh_q;

   assert_cnt_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == DIV_RUN) |-> (cnt_q != '0));
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (st_q == DIV_IDLE));
endmodule

// File: rtl/frac_dto_acc.sv
module frac_dto_acc #(
   parameter int PH_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic [PH_W-1:0] phase_i,
   output logic            pulse_o
);
   localparam int MOD = (1 << PH_W) - 1;

   logic [PH_W-1:0] acc_q;
   logic [PH_W:0]   sum;
   logic            wrap;

   always_comb begin
      sum  = {1'b0, acc_q} + {1'b0, phase_i};
      wrap = sum >= (PH_W+1)'(MOD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         pulse_o <= 1'b0;
      end else if (!en_i) begin
         acc_q   <= '0;
         pulse_o <= 1'b0;
      end else begin
         acc_q   <= wrap ? PH_W'(sum - (PH_W+1)'(MOD)) : sum[PH_W-1:0];
         pulse_o <= wrap;
      end
   end

   assert_acc_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < PH_W'(MOD));
   assert_full_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && phase_i == PH_W'(MOD)) |=> pulse_o);
   assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!pulse_o && acc_q == '0));
endmodule

// File: rtl/frac_clken_dto.sv
module frac_clken_dto
   import frac_dto_pkg::*;
#(
   parameter int NUM_INST = DEF_NUM_INST,
   parameter int RATE_W   = DEF_RATE_W,
   parameter int PH_W     = DEF_PH_W,
   parameter int IDX_W    = DEF_IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [IDX_W-1:0]    req_idx_i,
   input  logic [RATE_W-1:0]   req_ref_khz_i,
   input  logic [RATE_W-1:0]   req_tgt_khz_i,
   output logic                req_ready_o,
   output logic                upd_done_o,
   output logic                upd_clamped_o,
   input  logic [IDX_W-1:0]    stat_idx_i,
   output logic [PH_W-1:0]     stat_phase_o,
   output logic [PH_W-1:0]     stat_modulo_o,
   output logic                stat_en_o,
   output logic [RATE_W-1:0]   stat_last_khz_o,
   output logic [NUM_INST-1:0] clk_en_o
);
   localparam int MOD   = (1 << PH_W) - 1;
   localparam int NUM_W = RATE_W + PH_W + 1;
   localparam int IX_W  = $clog2(NUM_INST);

   if (NUM_INST < 2) begin : g_bad_inst
      $error("NUM_INST must be at least 2");
   end
   if (IDX_W < IX_W) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_INST");
   end
   if (PH_W < 2 || RATE_W < 1) begin : g_bad_w
      $error("PH_W and RATE_W out of range");
   end

   logic [PH_W-1:0]   ph_q   [NUM_INST];
   logic [PH_W-1:0]   md_q   [NUM_INST];
   logic [RATE_W-1:0] last_q [NUM_INST];
   logic [NUM_INST-1:0] en_q;
   logic              pend_q;
   logic [IX_W-1:0]   pend_idx_q;
   logic              idx_ok, zero_rate, accept, div_start;
   logic [NUM_W-1:0]  div_num, div_quo;
   logic              div_busy, div_done, over;
   logic [NUM_INST-1:0] wr_req, wr_done;

   // request decode
   assign idx_ok    = {1'b0, req_idx_i} < (IDX_W+1)'(NUM_INST);
   assign zero_rate = (req_ref_khz_i == '0) || (req_tgt_khz_i == '0);
   assign accept    = req_valid_i && !pend_q && idx_ok;
   assign div_start = accept && !zero_rate;
   assign div_num   = NUM_W'(req_tgt_khz_i) * NUM_W'(MOD)
                    + NUM_W'(req_ref_khz_i) - NUM_W'(1);
   assign over      = div_quo > NUM_W'(MOD);
   assign req_ready_o = !pend_q;

   frac_dto_div #(.NUM_W(NUM_W), .DEN_W(RATE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   (div_num),
      .den_i   (req_ref_khz_i),
      .busy_o  (div_busy),
      .done_o  (div_done),
      .quo_o   (div_quo)
   );

   // per-instance strobes and accumulators
   for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
      assign wr_req[g]  = accept && (req_idx_i == IDX_W'(g));
      assign wr_done[g] = div_done && (pend_idx_q == IX_W'(g));

      frac_dto_acc #(.PH_W(PH_W)) u_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_i    (en_q[g]),
         .phase_i (ph_q[g]),
         .pulse_o (clk_en_o[g])
      );

      assert_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_req[g] && zero_rate) |=> (!en_q[g] && $stable(ph_q[g]) && $stable(md_q[g])));
      assert_en_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
         wr_done[g] |=> (en_q[g] && md_q[g] == PH_W'(MOD)));
      assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_done[g] && over) |=> (ph_q[g] == PH_W'(MOD) && upd_clamped_o));
      assert_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
         wr_req[g] |=> (last_q[g] == $past(req_tgt_khz_i)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_INST; i++) begin
            ph_q[i]   <= '0;
            md_q[i]   <= '0;
            last_q[i] <= '0;
         end
         en_q          <= '0;
         pend_q        <= 1'b0;
         pend_idx_q    <= '0;
         upd_done_o    <= 1'b0;
         upd_clamped_o <= 1'b0;
      end else begin
         upd_done_o    <= 1'b0;
         upd_clamped_o <= 1'b0;
         if (div_start) begin
            pend_q     <= 1'b1;
            pend_idx_q <= req_idx_i[IX_W-1:0];
         end
         if (div_done) begin
            pend_q        <= 1'b0;
            upd_done_o    <= 1'b1;
            upd_clamped_o <= over;
         end
         for (int i = 0; i < NUM_INST; i++) begin
            if (wr_req[i]) begin
               last_q[i] <= req_tgt_khz_i;
               if (zero_rate) en_q[i] <= 1'b0;
            end
            if (wr_done[i]) begin
               ph_q[i] <= over ? PH_W'(MOD) : div_quo[PH_W-1:0];
               md_q[i] <= PH_W'(MOD);
               en_q[i] <= 1'b1;
            end
         end
      end
   end

   // status readback
   always_comb begin
      stat_phase_o    = '0;
      stat_modulo_o   = '0;
      stat_en_o       = 1'b0;
      stat_last_khz_o = '0;
      for (int i = 0; i < NUM_INST; i++) begin
         if (stat_idx_i == IDX_W'(i)) begin
            stat_phase_o    = ph_q[i];
            stat_modulo_o   = md_q[i];
            stat_en_o       = en_q[i];
            stat_last_khz_o = last_q[i];
         end
      end
   end

   assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      div_start |-> !div_busy);
   assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !idx_ok && !div_done) |=> $stable(en_q));
endmodule

// File: tb/frac_clken_dto_tb.sv
`timescale 1ns/1ps
module frac_clken_dto_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_idx = '0;
   logic [19:0] req_ref = '0;
   logic [19:0] req_tgt = '0;
   logic        req_ready, upd_done, upd_clamped;
   logic [2:0]  stat_idx = '0;
   logic [7:0]  stat_phase, stat_mod;
   logic        stat_en;
   logic [19:0] stat_last;
   logic [3:0]  clk_en;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   frac_clken_dto u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_idx_i(req_idx),
      .req_ref_khz_i(req_ref), .req_tgt_khz_i(req_tgt), .req_ready_o(req_ready),
      .upd_done_o(upd_done), .upd_clamped_o(upd_clamped), .stat_idx_i(stat_idx),
      .stat_phase_o(stat_phase), .stat_modulo_o(stat_mod), .stat_en_o(stat_en),
      .stat_last_khz_o(stat_last), .clk_en_o(clk_en)
   );

   localparam int NV = 8;
   localparam int T_IDX [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
   localparam int T_REF [NV] = '{100000, 100000, 300000, 600000, 100000, 7, 1, 1048575};
   localparam int T_TGT [NV] = '{50000, 100000, 1, 400000, 150000, 3, 1048575, 1048575};
   localparam int T_PH  [NV] = '{128, 255, 1, 170, 255, 110, 255, 255};
   localparam int T_CLP [NV] = '{0, 0, 0, 0, 1, 0, 1, 0};
   localparam int T_LAT [NV] = '{2, 1, 255, 2, 0, 0, 0, 0};

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic rd(input int idx);
      stat_idx = 3'(idx);
      #1;
   endtask

   task automatic send(input int idx, input int rf, input int tg, input bit wait_rdy);
      if (wait_rdy) while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_idx = 3'(idx); req_ref = 20'(rf); req_tgt = 20'(tg);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output bit seen, output bit clp);
      seen = 0; clp = 0;
      for (int n = 0; n < 200; n++) begin
         if (upd_done) begin seen = 1; clp = upd_clamped; break; end
         @(negedge clk);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
         summary();
      end
   end

   initial begin
      bit seen, clp;
      int lat, cnt;
      int s_ph [4];
      int s_en [4];
      int s_last [4];
      int done_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 / R1 reset state
      rd(0);
      chk("R11", "ready", req_ready, 1);
      chk("R11", "clk_en", clk_en, 0);
      chk("R11", "phase", stat_phase, 0);
      chk("R1", "modulo after reset", stat_mod, 0);
      chk("R11", "en", stat_en, 0);
      chk("R11", "last", stat_last, 0);

      // vector table: R2 R3 R5 R1 R7 R8 R9
      for (int v = 0; v < NV; v++) begin
         send(T_IDX[v], T_REF[v], T_TGT[v], 1);
         chk("R10", "ready low while dividing", req_ready, 0);
         wait_done(seen, clp);
         chk("R5", "done pulse seen", seen, 1);
         chk("R3", "clamp flag", clp, T_CLP[v]);
         rd(T_IDX[v]);
         chk("R2", "phase", stat_phase, T_PH[v]);
         chk("R1", "modulo", stat_mod, 255);
         chk("R5", "enable", stat_en, 1);
         chk("R7", "last rate", stat_last, T_TGT[v]);
         if (T_LAT[v] != 0) begin
            lat = 0;
            for (int n = 1; n <= 300; n++) begin
               @(negedge clk);
               if (clk_en[T_IDX[v]]) begin lat = n; break; end
            end
            chk("R9", "first pulse latency", lat, T_LAT[v]);
            cnt = 0;
            for (int n = 0; n < 255; n++) begin
               @(negedge clk);
               if (clk_en[T_IDX[v]]) cnt++;
            end
            chk("R8", "pulses per 255 cycles", cnt, T_PH[v]);
         end
      end

      // R4 zero reference rate on instance 0
      send(0, 0, 777, 1);
      rd(0);
      chk("R4", "en after zero ref", stat_en, 0);
      chk("R4", "phase kept", stat_phase, 255);
      chk("R4", "modulo kept", stat_mod, 255);
      chk("R7", "last on zero ref", stat_last, 777);
      chk("R4", "ready stays high", req_ready, 1);
      cnt = 0; done_cnt = 0;
      for (int n = 0; n < 300; n++) begin
         @(negedge clk);
         if (clk_en[0]) cnt++;
         if (upd_done) done_cnt++;
      end
      chk("R9", "pulses while off", cnt, 0);
      chk("R4", "no done on zero rate", done_cnt, 0);

      // R4 zero requested rate on instance 1
      send(1, 5, 0, 1);
      rd(1);
      chk("R4", "en after zero tgt", stat_en, 0);
      chk("R4", "phase kept inst1", stat_phase, 110);
      chk("R7", "last zero", stat_last, 0);

      // R9 re-enable from off gives deterministic first pulse
      send(0, 100000, 50000, 1);
      wait_done(seen, clp);
      chk("R5", "re-enable done", seen, 1);
      lat = 0;
      for (int n = 1; n <= 300; n++) begin
         @(negedge clk);
         if (clk_en[0]) begin lat = n; break; end
      end
      chk("R9", "re-enable latency", lat, 2);

      // R6 out-of-range index
      for (int i = 0; i < 4; i++) begin
         rd(i); s_ph[i] = stat_phase; s_en[i] = stat_en; s_last[i] = stat_last;
      end
      send(5, 100, 50, 1);
      done_cnt = 0; cnt = 0;
      for (int n = 0; n < 40; n++) begin
         @(negedge clk);
         if (upd_done) done_cnt++;
         if (!req_ready) cnt++;
      end
      chk("R6", "no done for bad index", done_cnt, 0);
      chk("R6", "never busy for bad index", cnt, 0);
      for (int i = 0; i < 4; i++) begin
         rd(i);
         chk("R6", "phase untouched", stat_phase, s_ph[i]);
         chk("R6", "en untouched", stat_en, s_en[i]);
         chk("R6", "last untouched", stat_last, s_last[i]);
      end
      rd(5);
      chk("R6", "status of bad index", {stat_phase, stat_mod, stat_en, stat_last}, 0);

      // R10 request while busy is dropped
      send(2, 300000, 150000, 1);
      chk("R10", "busy after accept", req_ready, 0);
      send(3, 10, 10, 0);
      wait_done(seen, clp);
      chk("R10", "first request done", seen, 1);
      rd(2);
      chk("R2", "phase rounded up", stat_phase, 128);
      done_cnt = 0;
      for (int n = 0; n < 40; n++) begin
         @(negedge clk);
         if (upd_done) done_cnt++;
      end
      chk("R10", "no second done", done_cnt, 0);
      rd(3);
      chk("R10", "dropped request phase", stat_phase, 255);
      chk("R10", "dropped request last", stat_last, 1048575);

      summary();
   end
endmodule